// File: doc/BRIEF.md
# Dual-Mode Saturating Error Counter with Snapshot Buffer

This block keeps a saturating error count for an E1 receive framer. One select input picks what is counted. In the first mode, the block counts far-end error-indication codes carried in the Sa6 spare bits. Each CRC submultiframe delivers one 4-bit Sa6 code, and a code of 0001 or 0011 adds one to the count. In the second mode, the block counts bit errors reported by a pseudo-random test-pattern receiver. Each mode is gated by its own lock flag. Each mode also has its own alarm-simulation increment rule, which lets software exercise the count path without real errors.

Software reads the count through a buffer that has a low-byte port and a high-byte port. In continuous update mode, the buffer follows the live counter. A snapshot request freezes the buffer at the current count and restarts the live counter from zero. The request stays pending until the high byte is read, and then it clears itself. In hold mode, the buffer is loaded only by a snapshot request.

Top module: `dual_err_counter`

## Requirements
- R1: A synchronous active-high reset clears the live counter, the buffer, the pending request and the alarm bit parity.
- R2: With `cnt_sel`=0 and `crc_mf_en`=1 and `mf_locked`=1, each `sa6_valid` strobe adds one to the count only when `sa6_code` is 4'b0001 or 4'b0011. Bit 3 holds the first Sa6 bit received and bit 0 holds the last. All other codes add nothing.
- R3: In Sa6 mode, no strobe counts while `mf_locked`=0. No strobe counts while `crc_mf_en`=0, which is the doubleframe format.
- R4: With `cnt_sel`=1 and `alarm_sim`=0, a cycle with `prbs_bit_valid`, `prbs_err` and `prbs_locked` all high adds one. Without `prbs_locked`, nothing is counted.
- R5: The counter stops at all-ones (0xFFFF at the default width) and never wraps. Each cycle it changes by at most +1, except for a clear.
- R6: In Sa6 mode with `alarm_sim`=1, every `sa6_valid` strobe counts whatever its code, but the multiframe lock gate still applies.
- R7: In PRBS mode with `alarm_sim`=1, every second `prbs_bit_valid` counts whatever `prbs_err` and `prbs_locked` are. The bit parity restarts whenever `alarm_sim` is low, so the first bit after enabling does not count.
- R8: With `hold_mode`=0 and no pending request, the buffer takes the live count one cycle after the counter changes.
- R9: A `snap_set` pulse while no request is pending sets `snap_pending`, loads the buffer with the count held before that edge, and clears the live counter. An increment in the same cycle is dropped.
- R10: While `snap_pending`=1, the buffer is frozen. A `rd_hi` strobe clears `snap_pending`. The buffer does not update on that edge and resumes on the edge after it.
- R11: With `hold_mode`=1, the buffer changes only on a snapshot request.
- R12: The source that is not selected has no effect: Sa6 strobes are ignored in PRBS mode, and PRBS error strobes are ignored in Sa6 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_sel | input | 1 | Count source: 0 = Sa6 codes, 1 = PRBS bit errors |
| crc_mf_en | input | 1 | 1 = CRC multiframe format, 0 = doubleframe format |
| mf_locked | input | 1 | Multiframe alignment held |
| prbs_locked | input | 1 | PRBS receiver synchronous |
| sa6_valid | input | 1 | One-cycle strobe per received submultiframe |
| sa6_code | input | 4 | Sa6 code, first received bit in bit 3 |
| prbs_bit_valid | input | 1 | Strobe per received pattern bit |
| prbs_err | input | 1 | The pattern bit in this cycle is in error |
| alarm_sim | input | 1 | Alarm-simulation enable |
| hold_mode | input | 1 | 0 = continuous buffer update, 1 = update on snapshot only |
| snap_set | input | 1 | Write pulse that sets the snapshot request |
| rd_hi | input | 1 | High-byte read strobe, clears the request |
| snap_pending | output | 1 | Snapshot request pending |
| rd_lo_byte | output | CNT_W/2 | Low half of the buffer |
| rd_hi_byte | output | CNT_W/2 | High half of the buffer |

## Verification
The bench builds the block with its default 16-bit counter and 8-bit read halves. At that width a held PRBS error stream reaches 0xFFFF in about 65,536 cycles, which tests saturation at the real width and still fits inside the run. A mid-range value such as 0x012C places distinct data in each read byte, so it shows any swap of the two halves.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;

    typedef enum logic {
        SRC_SA6  = 1'b0,
        SRC_PRBS = 1'b1
    } src_e;

    typedef enum logic {
        FMT_DOUBLE = 1'b0,
        FMT_CRCMF  = 1'b1
    } fmt_e;

    localparam int SA6_W = 4;
    localparam logic [SA6_W-1:0] SA6_ERR_A = 4'b0001;
    localparam logic [SA6_W-1:0] SA6_ERR_B = 4'b0011;

    typedef struct packed {
        logic             valid;
        logic [SA6_W-1:0] code;
    } sa6_in_t;

    typedef struct packed {
        logic bit_valid;
        logic err;
    } prbs_in_t;

    typedef struct packed {
        logic locked_mf;
        logic locked_prbs;
        logic alarm;
    } gate_t;

    function automatic logic sa6_is_error(input logic [SA6_W-1:0] c);
        return (c == SA6_ERR_A) || (c == SA6_ERR_B);
    endfunction

endpackage

// File: rtl/ecnt_event_sel.sv
module ecnt_event_sel
    import ecnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_e     src,
    input  fmt_e     fmt,
    input  gate_t    gate,
    input  sa6_in_t  sa6,
    input  prbs_in_t prbs,
    output logic     inc
);

    logic phase_q;
    logic sa6_hit;
    logic prbs_hit;
    logic prbs_alarm;

    assign prbs_alarm = gate.alarm && (src == SRC_PRBS);

    // Bit parity for the alarm-simulation rule: every second bit counts.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else if (prbs_alarm) begin
            phase_q <= phase_q ^ prbs.bit_valid;
        end else begin
            phase_q <= 1'b0;
        end
    end

    always_comb begin
        sa6_hit = (fmt == FMT_CRCMF) && gate.locked_mf && sa6.valid &&
                  (gate.alarm || sa6_is_error(sa6.code));
        if (gate.alarm) begin
            prbs_hit = prbs.bit_valid && phase_q;
        end else begin
            prbs_hit = prbs.bit_valid && prbs.err && gate.locked_prbs;
        end
        inc = (src == SRC_SA6) ? sa6_hit : prbs_hit;
    end

endmodule

// File: rtl/ecnt_sat_counter.sv
module ecnt_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_max;
    assign at_max = (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && !at_max) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ecnt_snap_ctrl.sv
module ecnt_snap_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_set,
    input  logic             rd_hi,
    input  logic             hold_mode,
    input  logic [CNT_W-1:0] live_cnt,
    output logic             pending,
    output logic             snap_rise,
    output logic [CNT_W-1:0] hold_buf
);

    assign snap_rise = snap_set && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (snap_rise) begin
            pending <= 1'b1;
        end else if (rd_hi && pending) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_buf <= '0;
        end else if (snap_rise) begin
            hold_buf <= live_cnt;
        end else if (!pending && !hold_mode) begin
            hold_buf <= live_cnt;
        end
    end

endmodule

// File: rtl/dual_err_counter.sv
module dual_err_counter
    import ecnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_sel,
    input  logic                 crc_mf_en,
    input  logic                 mf_locked,
    input  logic                 prbs_locked,
    input  logic                 sa6_valid,
    input  logic [3:0]           sa6_code,
    input  logic                 prbs_bit_valid,
    input  logic                 prbs_err,
    input  logic                 alarm_sim,
    input  logic                 hold_mode,
    input  logic                 snap_set,
    input  logic                 rd_hi,
    output logic                 snap_pending,
    output logic [CNT_W/2-1:0]   rd_lo_byte,
    output logic [CNT_W/2-1:0]   rd_hi_byte
);

    localparam int HALF_W = CNT_W / 2;

    src_e             src;
    fmt_e             fmt;
    gate_t            gate;
    sa6_in_t          sa6;
    prbs_in_t         prbs;
    logic             inc;
    logic             snap_rise;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] snap_buf;

    assign src  = src_e'(cnt_sel);
    assign fmt  = fmt_e'(crc_mf_en);
    assign gate = '{locked_mf: mf_locked, locked_prbs: prbs_locked, alarm: alarm_sim};
    assign sa6  = '{valid: sa6_valid, code: sa6_code};
    assign prbs = '{bit_valid: prbs_bit_valid, err: prbs_err};

    ecnt_event_sel u_evt (
        .clk  (clk),
        .rst  (rst),
        .src  (src),
        .fmt  (fmt),
        .gate (gate),
        .sa6  (sa6),
        .prbs (prbs),
        .inc  (inc)
    );

    ecnt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (snap_rise),
        .inc   (inc),
        .count (live_cnt)
    );

    ecnt_snap_ctrl #(.CNT_W(CNT_W)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .snap_set  (snap_set),
        .rd_hi     (rd_hi),
        .hold_mode (hold_mode),
        .live_cnt  (live_cnt),
        .pending   (snap_pending),
        .snap_rise (snap_rise),
        .hold_buf  (snap_buf)
    );

    for (genvar b = 0; b < HALF_W; b++) begin : g_lane
        assign rd_lo_byte[b] = snap_buf[b];
        assign rd_hi_byte[b] = snap_buf[HALF_W + b];
    end

endmodule

// File: rtl/ecnt_checker.sv
module ecnt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             src,
    input logic             crc_mf_en,
    input logic             snap_set,
    input logic             rd_hi,
    input logic             pending,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] hold_buf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == CNT_MAX && !(snap_set && !pending)) |=> (live_cnt == CNT_MAX));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(live_cnt) |=> (live_cnt == $past(live_cnt)) ||
                                  (live_cnt == $past(live_cnt) + 1'b1) ||
                                  (live_cnt == '0));

    // R9
    rise_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> (live_cnt == '0));

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && $past(pending)) |-> $stable(hold_buf));

    // R10
    rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && pending) |=> !pending);

    // R3
    dbl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!src && !crc_mf_en && !snap_set) |=> $stable(live_cnt));

endmodule

bind dual_err_counter ecnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src       (cnt_sel),
    .crc_mf_en (crc_mf_en),
    .snap_set  (snap_set),
    .rd_hi     (rd_hi),
    .pending   (snap_pending),
    .live_cnt  (live_cnt),
    .hold_buf  (snap_buf)
);

// File: tb/dual_err_counter_test.sv
module dual_err_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst, cnt_sel, crc_mf_en, mf_locked, prbs_locked;
    logic sa6_valid, prbs_bit_valid, prbs_err, alarm_sim, hold_mode, snap_set, rd_hi;
    logic [3:0] sa6_code;
    logic snap_pending;
    logic [7:0] rd_lo_byte, rd_hi_byte;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int total = 0;

    // {code, expected hit}
    localparam logic [4:0] SA6_VEC [16] = '{
        {4'h0,1'b0}, {4'h1,1'b1}, {4'h2,1'b0}, {4'h3,1'b1},
        {4'h4,1'b0}, {4'h5,1'b0}, {4'h6,1'b0}, {4'h7,1'b0},
        {4'h8,1'b0}, {4'h9,1'b0}, {4'hA,1'b0}, {4'hB,1'b0},
        {4'hC,1'b0}, {4'hD,1'b0}, {4'hE,1'b0}, {4'hF,1'b0}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_err_counter #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cnt_sel(cnt_sel), .crc_mf_en(crc_mf_en),
        .mf_locked(mf_locked), .prbs_locked(prbs_locked), .sa6_valid(sa6_valid),
        .sa6_code(sa6_code), .prbs_bit_valid(prbs_bit_valid), .prbs_err(prbs_err),
        .alarm_sim(alarm_sim), .hold_mode(hold_mode), .snap_set(snap_set),
        .rd_hi(rd_hi), .snap_pending(snap_pending), .rd_lo_byte(rd_lo_byte),
        .rd_hi_byte(rd_hi_byte)
    );

    function automatic logic [15:0] rd_buf();
        return {rd_hi_byte, rd_lo_byte};
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sa6_pulse(input logic [3:0] c);
        sa6_code = c; sa6_valid = 1'b1;
        cyc(1);
        sa6_valid = 1'b0;
    endtask

    task automatic prbs_bit(input logic e);
        prbs_bit_valid = 1'b1; prbs_err = e;
        cyc(1);
        prbs_bit_valid = 1'b0; prbs_err = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_sel = 1'b0; crc_mf_en = 1'b0; mf_locked = 1'b0; prbs_locked = 1'b0;
        sa6_valid = 1'b0; sa6_code = 4'h0; prbs_bit_valid = 1'b0; prbs_err = 1'b0;
        alarm_sim = 1'b0; hold_mode = 1'b0; snap_set = 1'b0; rd_hi = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 buffer", rd_buf(), 0);
        check("R1 pending", snap_pending, 0);

        // R2: table walk over all 16 codes
        crc_mf_en = 1'b1; mf_locked = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sa6_pulse(SA6_VEC[i][4:1]);
            total += SA6_VEC[i][0];
            cyc(1);
            check("R2 code table", rd_buf(), total);
        end

        // R3: lock loss and doubleframe
        mf_locked = 1'b0;
        sa6_pulse(4'h1); cyc(1);
        check("R3 no mf lock", rd_buf(), total);
        mf_locked = 1'b1; crc_mf_en = 1'b0;
        sa6_pulse(4'h3); cyc(1);
        check("R3 doubleframe", rd_buf(), total);
        crc_mf_en = 1'b1;

        // R12: PRBS errors ignored in Sa6 mode
        prbs_locked = 1'b1;
        repeat (4) prbs_bit(1'b1);
        cyc(1);
        check("R12 prbs in sa6 mode", rd_buf(), total);

        // R6: Sa6 alarm simulation
        alarm_sim = 1'b1;
        repeat (3) sa6_pulse(4'hF);
        total += 3;
        cyc(1);
        check("R6 sa6 alarm", rd_buf(), total);
        mf_locked = 1'b0;
        sa6_pulse(4'h1); cyc(1);
        check("R6 alarm needs mf lock", rd_buf(), total);
        mf_locked = 1'b1; alarm_sim = 1'b0;

        // R12: Sa6 ignored in PRBS mode
        cnt_sel = 1'b1;
        sa6_pulse(4'h1); cyc(1);
        check("R12 sa6 in prbs mode", rd_buf(), total);

        // R4: PRBS errors with and without lock
        prbs_bit(1'b1); prbs_bit(1'b0); prbs_bit(1'b1); prbs_bit(1'b1); prbs_bit(1'b0);
        total += 3;
        cyc(1);
        check("R4 locked errors", rd_buf(), total);
        prbs_locked = 1'b0;
        repeat (3) prbs_bit(1'b1);
        cyc(1);
        check("R4 unlocked errors", rd_buf(), total);

        // R7: PRBS alarm simulation, every second bit
        alarm_sim = 1'b1;
        repeat (5) prbs_bit(1'b0);
        total += 2;
        cyc(1);
        check("R7 every second bit", rd_buf(), total);
        alarm_sim = 1'b0; cyc(1);
        alarm_sim = 1'b1;
        repeat (3) prbs_bit(1'b0);
        total += 1;
        cyc(1);
        check("R7 parity restart", rd_buf(), total);
        alarm_sim = 1'b0; prbs_locked = 1'b1;

        // R8: buffer lags the counter by one cycle
        prbs_bit(1'b1);
        check("R8 before buffer load", rd_buf(), total);
        total += 1;
        cyc(1);
        check("R8 after buffer load", rd_buf(), total);

        // R9/R10: snapshot with coincident event
        snap_set = 1'b1; prbs_bit_valid = 1'b1; prbs_err = 1'b1;
        cyc(1);
        snap_set = 1'b0; prbs_bit_valid = 1'b0; prbs_err = 1'b0;
        check("R9 pending set", snap_pending, 1);
        check("R9 buffer captured", rd_buf(), total);
        repeat (3) prbs_bit(1'b1);
        cyc(1);
        check("R10 frozen", rd_buf(), total);
        rd_hi = 1'b1; cyc(1); rd_hi = 1'b0;
        check("R10 pending cleared", snap_pending, 0);
        check("R10 no update on clear edge", rd_buf(), total);
        cyc(1);
        check("R9 restart from zero, coincident dropped", rd_buf(), 3);

        // R11: hold mode
        hold_mode = 1'b1;
        repeat (4) prbs_bit(1'b1);
        cyc(2);
        check("R11 hold no follow", rd_buf(), 3);
        snap_set = 1'b1; cyc(1); snap_set = 1'b0;
        check("R11 snapshot loads", rd_buf(), 7);
        rd_hi = 1'b1; cyc(1); rd_hi = 1'b0;
        cyc(2);
        check("R11 stays after release", rd_buf(), 7);
        hold_mode = 1'b0;
        cyc(2);
        check("R8 continuous resumes", rd_buf(), 0);

        // R5: byte split and saturation
        prbs_bit_valid = 1'b1; prbs_err = 1'b1;
        cyc(300);
        prbs_bit_valid = 1'b0; prbs_err = 1'b0;
        cyc(1);
        check("R5 high byte split", rd_hi_byte, 8'h01);
        check("R5 low byte split", rd_lo_byte, 8'h2C);
        prbs_bit_valid = 1'b1; prbs_err = 1'b1;
        cyc(65300);
        prbs_bit_valid = 1'b0; prbs_err = 1'b0;
        cyc(1);
        check("R5 saturated", rd_buf(), 16'hFFFF);
        repeat (5) prbs_bit(1'b1);
        cyc(1);
        check("R5 no wrap", rd_buf(), 16'hFFFF);

        // R1: reset mid-run
        rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
        check("R1 reset clears", rd_buf(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule